// File: doc/BRIEF.md
# Interrupt Pending Latch Bank

This block holds the pending state of every interrupt an interrupt distributor manages. Each interrupt is either edge-triggered or level-triggered, chosen by a per-interrupt configuration input. Pending is stored as two parts: a software latch and a copy of the live line level. The latch is set by input edges (edge mode) or by set-pending writes. It is cleared by activation pulses or clear-pending writes. The level copy follows the interrupt line.

Two word-addressed register ports reach the same state with different rules. The guest port shows what a running guest sees: for level interrupts, pending is the OR of latch and line, and status bits are write-one-to-clear. The save/restore port gives raw access to the latch, the line levels, the status bits and the interrupt count, so a controller's whole state can be captured and reloaded. The save/restore port refuses every access with an error while the CPU-running flag is high.

Both ports are plain strobes with no back-pressure. Every strobe is accepted in the cycle it is raised, and its response comes in the next cycle.

Top module: `irq_pend_bank`

## Requirements
- R1: The latch bit of an interrupt with `irq_edge`=1 becomes 1 in the cycle after its line is sampled high when it was sampled low on the previous edge. A guest write of 1 to a set-pending bit sets the latch in either mode.
- R2: A latch bit clears only on an `irq_act` pulse or a guest clear-pending write of 1. When a set event and a clear event hit the same interrupt in one cycle, the set wins.
- R3: Guest reads of the set-pending and clear-pending regions return latch OR line level for level interrupts (`irq_edge`=0), and the latch alone for edge interrupts. A clear-pending write or activation therefore leaves a level interrupt pending while its line stays high.
- R4: Save/restore reads of the set-pending region return the raw latch. Save/restore writes load the latch word directly.
- R5: On the save/restore port, the clear-pending region reads as zero and ignores writes.
- R6: Status word bit 0 is set by a refused save/restore access. Bit 1 is set by a rejected count write. Bits 31:2 read as zero. A guest write clears the bits written as 1. A save/restore write loads bits 1:0 with the value written. A new event wins over a clear in the same cycle.
- R7: Save/restore line-level word n covers interrupts 32n to 32n+31, with bit b standing for interrupt 32n+b and 1 meaning asserted. Interrupts 0 to 15, and IDs at or above the configured count, read as zero and ignore writes. A restored level never creates an edge, and a later change on the line overrides it.
- R8: The interrupt count resets to NIRQ. A save/restore write is accepted only for a value from 64 to NIRQ that is a multiple of 32. Any other value keeps the old count and returns `s_err`.
- R9: While `cpu_running` is 1, every save/restore access returns `s_err`=1 and read data 0, and changes nothing except status bit 0.
- R10: Guest writes to the read-only count and to the line-level region are ignored. Guest reads of the line-level region return zero.
- R11: Address bits [AW-1:AW-2] select the region: 0 control (word 0 status, word 1 count), 1 set-pending, 2 clear-pending, 3 line level. The low bits select the word. Each strobe is answered one cycle later by ack with read data; writes return data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NIRQ | Interrupt input lines |
| irq_edge | input | NIRQ | Trigger mode per interrupt, 1 = edge |
| irq_act | input | NIRQ | Activation pulses, clear the latch |
| cpu_running | input | 1 | Blocks the save/restore port when 1 |
| g_req | input | 1 | Guest port strobe |
| g_we | input | 1 | Guest port write enable |
| g_addr | input | AW | Guest port word address |
| g_wdata | input | 32 | Guest port write data |
| g_ack | output | 1 | Guest response valid |
| g_rdata | output | 32 | Guest read data |
| s_req | input | 1 | Save/restore port strobe |
| s_we | input | 1 | Save/restore port write enable |
| s_addr | input | AW | Save/restore port word address |
| s_wdata | input | 32 | Save/restore port write data |
| s_ack | output | 1 | Save/restore response valid |
| s_err | output | 1 | Save/restore error (busy or bad count) |
| s_rdata | output | 32 | Save/restore read data |

## Verification
The assertions check, on every cycle, that a rising edge on an edge-mode line leaves its latch set, that busy accesses always return an error with zero data, that the clear-pending region reads zero on the save port, that the count never leaves its legal range, and that each guest strobe is acknowledged. Some behaviours can only be shown by the bench's scenarios, because they depend on a history of accesses. These include the difference between the guest view and the raw latch for level interrupts, and the status bits being cleared on one port and loaded on the other. They also include the masking of low IDs and IDs past the count in line-level access, and the fact that a restored level creates no edge.

// File: rtl/pend_pkg.sv
package pend_pkg;
  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_SETP = 2'd1,
    RG_CLRP = 2'd2,
    RG_LINE = 2'd3
  } region_e;

  localparam int unsigned STAT_W   = 2;
  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_BADC  = 1;
  localparam int unsigned MIN_IRQ  = 64;
  localparam int unsigned NUM_SGI  = 16;
  localparam int unsigned WORD_W   = 32;
endpackage

// File: rtl/pend_word.sv
module pend_word #(
  parameter int unsigned BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] line_in,
  input  logic [BITS-1:0] edge_mode,
  input  logic [BITS-1:0] activate,
  input  logic [BITS-1:0] set_bits,
  input  logic [BITS-1:0] clr_bits,
  input  logic            load_en,
  input  logic [BITS-1:0] load_val,
  input  logic            lvl_en,
  input  logic [BITS-1:0] lvl_val,
  input  logic [BITS-1:0] lvl_mask,
  output logic [BITS-1:0] latch_q,
  output logic [BITS-1:0] level_q,
  output logic [BITS-1:0] view
);
  logic [BITS-1:0] prev_q, rise, set_ev, clr_ev, base, changed, lvl_keep;

  always_comb begin
    rise     = line_in & ~prev_q;
    set_ev   = (rise & edge_mode) | set_bits;
    clr_ev   = activate | clr_bits;
    base     = load_en ? load_val : latch_q;
    changed  = line_in ^ prev_q;
    lvl_keep = lvl_en ? ((lvl_mask & lvl_val) | (~lvl_mask & level_q)) : level_q;
    view     = latch_q | (~edge_mode & level_q);
  end

  // set has priority over clear; a raw load is applied before both
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      level_q <= '0;
      prev_q  <= '0;
    end else begin
      latch_q <= set_ev | (base & ~clr_ev);
      level_q <= (changed & line_in) | (~changed & lvl_keep);
      prev_q  <= line_in;
    end
  end
endmodule

// File: rtl/pend_ctrl.sv
module pend_ctrl import pend_pkg::*; #(
  parameter  int unsigned NIRQ = 128,
  localparam int unsigned CW   = $clog2(NIRQ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_w1c,
  input  logic [STAT_W-1:0] st_w1c_val,
  input  logic              st_load,
  input  logic [STAT_W-1:0] st_load_val,
  input  logic              ev_busy,
  input  logic              cnt_wr,
  input  logic [31:0]       cnt_val,
  output logic              cnt_bad,
  output logic [STAT_W-1:0] status_q,
  output logic [CW-1:0]     count_q
);
  logic              cnt_ok;
  logic [STAT_W-1:0] st_n, ev;

  assign cnt_ok  = (cnt_val >= 32'(MIN_IRQ)) && (cnt_val <= 32'(NIRQ)) && (cnt_val[4:0] == 5'd0);
  assign cnt_bad = cnt_wr && !cnt_ok;

  always_comb begin
    ev          = '0;
    ev[ST_BUSY] = ev_busy;
    ev[ST_BADC] = cnt_bad;
    st_n        = status_q;
    if (st_w1c)  st_n = st_n & ~st_w1c_val;
    if (st_load) st_n = st_load_val;
    st_n = st_n | ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      count_q  <= CW'(NIRQ);
    end else begin
      status_q <= st_n;
      if (cnt_wr && cnt_ok) count_q <= cnt_val[CW-1:0];
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank import pend_pkg::*; #(
  parameter  int unsigned NIRQ = 128,
  localparam int unsigned W    = NIRQ / WORD_W,
  localparam int unsigned WB   = $clog2(W),
  localparam int unsigned AW   = WB + 2,
  localparam int unsigned CW   = $clog2(NIRQ + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_line,
  input  logic [NIRQ-1:0] irq_edge,
  input  logic [NIRQ-1:0] irq_act,
  input  logic            cpu_running,
  input  logic            g_req,
  input  logic            g_we,
  input  logic [AW-1:0]   g_addr,
  input  logic [31:0]     g_wdata,
  output logic            g_ack,
  output logic [31:0]     g_rdata,
  input  logic            s_req,
  input  logic            s_we,
  input  logic [AW-1:0]   s_addr,
  input  logic [31:0]     s_wdata,
  output logic            s_ack,
  output logic            s_err,
  output logic [31:0]     s_rdata
);
  region_e           g_reg, s_reg;
  logic [WB-1:0]     g_idx, s_idx;
  logic              s_ok, g_wr, s_wr;
  logic [31:0]       latch_w [W];
  logic [31:0]       level_w [W];
  logic [31:0]       view_w  [W];
  logic [31:0]       mask_w  [W];
  logic [NIRQ-1:0]   latch_all;
  logic [STAT_W-1:0] status_q;
  logic [CW-1:0]     count_q;
  logic              cnt_bad;
  logic [31:0]       g_rd, s_rd;

  assign g_reg = region_e'(g_addr[AW-1 -: 2]);
  assign s_reg = region_e'(s_addr[AW-1 -: 2]);
  assign g_idx = g_addr[WB-1:0];
  assign s_idx = s_addr[WB-1:0];
  assign s_ok  = s_req && !cpu_running;
  assign g_wr  = g_req && g_we;
  assign s_wr  = s_ok && s_we;

  for (genvar w = 0; w < W; w++) begin : g_word
    logic g_hit, s_hit;
    assign g_hit = (g_idx == WB'(w));
    assign s_hit = (s_idx == WB'(w));
    assign latch_all[WORD_W*w +: WORD_W] = latch_w[w];

    pend_word #(.BITS(WORD_W)) u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (irq_line[WORD_W*w +: WORD_W]),
      .edge_mode (irq_edge[WORD_W*w +: WORD_W]),
      .activate  (irq_act[WORD_W*w +: WORD_W]),
      .set_bits  ((g_wr && g_hit && g_reg == RG_SETP) ? g_wdata : 32'd0),
      .clr_bits  ((g_wr && g_hit && g_reg == RG_CLRP) ? g_wdata : 32'd0),
      .load_en   (s_wr && s_hit && s_reg == RG_SETP),
      .load_val  (s_wdata),
      .lvl_en    (s_wr && s_hit && s_reg == RG_LINE),
      .lvl_val   (s_wdata),
      .lvl_mask  (mask_w[w]),
      .latch_q   (latch_w[w]),
      .level_q   (level_w[w]),
      .view      (view_w[w])
    );

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (WORD_W * w + b < NUM_SGI) begin : g_sgi
        assign mask_w[w][b] = 1'b0;
      end else begin : g_spi
        assign mask_w[w][b] = (CW'(WORD_W * w + b) < count_q);
      end
    end
  end

  pend_ctrl #(.NIRQ(NIRQ)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_w1c      (g_wr && g_reg == RG_CTRL && g_idx == WB'(0)),
    .st_w1c_val  (g_wdata[STAT_W-1:0]),
    .st_load     (s_wr && s_reg == RG_CTRL && s_idx == WB'(0)),
    .st_load_val (s_wdata[STAT_W-1:0]),
    .ev_busy     (s_req && cpu_running),
    .cnt_wr      (s_wr && s_reg == RG_CTRL && s_idx == WB'(1)),
    .cnt_val     (s_wdata),
    .cnt_bad     (cnt_bad),
    .status_q    (status_q),
    .count_q     (count_q)
  );

  always_comb begin
    g_rd = '0;
    s_rd = '0;
    for (int w = 0; w < W; w++) begin
      if (g_idx == WB'(w) && (g_reg == RG_SETP || g_reg == RG_CLRP)) g_rd = view_w[w];
      if (s_idx == WB'(w)) begin
        if (s_reg == RG_SETP)      s_rd = latch_w[w];
        else if (s_reg == RG_LINE) s_rd = level_w[w] & mask_w[w];
      end
    end
    if (g_reg == RG_CTRL) begin
      if (g_idx == WB'(0))      g_rd = 32'(status_q);
      else if (g_idx == WB'(1)) g_rd = 32'(count_q);
    end
    if (s_reg == RG_CTRL) begin
      if (s_idx == WB'(0))      s_rd = 32'(status_q);
      else if (s_idx == WB'(1)) s_rd = 32'(count_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_ack   <= 1'b0;
      g_rdata <= '0;
      s_ack   <= 1'b0;
      s_err   <= 1'b0;
      s_rdata <= '0;
    end else begin
      g_ack   <= g_req;
      g_rdata <= (g_req && !g_we) ? g_rd : 32'd0;
      s_ack   <= s_req;
      s_err   <= s_req && (cpu_running || cnt_bad);
      s_rdata <= (s_ok && !s_we) ? s_rd : 32'd0;
    end
  end
endmodule

// File: rtl/pend_chk.sv
module pend_chk import pend_pkg::*; #(
  parameter  int unsigned NIRQ = 128,
  localparam int unsigned AW   = $clog2(NIRQ / WORD_W) + 2,
  localparam int unsigned CW   = $clog2(NIRQ + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NIRQ-1:0] irq_line,
  input logic [NIRQ-1:0] irq_edge,
  input logic            cpu_running,
  input logic            g_req,
  input logic            g_ack,
  input logic            s_req,
  input logic            s_we,
  input logic [AW-1:0]   s_addr,
  input logic            s_err,
  input logic [31:0]     s_rdata,
  input logic [CW-1:0]   count_q,
  input logic [NIRQ-1:0] latch_all
);
  logic [NIRQ-1:0] prv_q, rise_e;

  always_ff @(posedge clk) begin
    if (!rst_n) prv_q <= '0;
    else        prv_q <= irq_line;
  end
  assign rise_e = irq_line & ~prv_q & irq_edge;

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_e != '0) |=> ((latch_all & $past(rise_e)) == $past(rise_e))); // R1
  AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req && cpu_running) |=> (s_err && s_rdata == 32'd0)); // R9
  AST_CLRP_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req && !s_we && s_addr[AW-1 -: 2] == RG_CLRP) |=> (s_rdata == 32'd0)); // R5
  AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q >= CW'(MIN_IRQ)) && (count_q <= CW'(NIRQ)) && (count_q[4:0] == 5'd0)); // R8
  AST_GUEST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    g_req |=> g_ack); // R11
endmodule

bind irq_pend_bank pend_chk #(.NIRQ(NIRQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_line    (irq_line),
  .irq_edge    (irq_edge),
  .cpu_running (cpu_running),
  .g_req       (g_req),
  .g_ack       (g_ack),
  .s_req       (s_req),
  .s_we        (s_we),
  .s_addr      (s_addr),
  .s_err       (s_err),
  .s_rdata     (s_rdata),
  .count_q     (count_q),
  .latch_all   (latch_all)
);

// File: tb/sim_irq_pend_bank.sv
module sim_irq_pend_bank;
  localparam int NI = 128;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] line = '0, edgec = '0, act = '0;
  logic cpu_run = 1'b0;
  logic g_req = 1'b0, g_we = 1'b0;
  logic [AW-1:0] g_addr = '0;
  logic [31:0] g_wdata = '0;
  logic s_req = 1'b0, s_we = 1'b0;
  logic [AW-1:0] s_addr = '0;
  logic [31:0] s_wdata = '0;
  logic g_ack, s_ack, s_err;
  logic [31:0] g_rdata, s_rdata;

  int n_chk = 0, n_fail = 0;
  logic [NI-1:0] m_latch = '0, m_lvl = '0, m_prev = '0;
  logic [1:0] m_stat = '0;
  int m_cnt = NI;

  always #10 clk = ~clk;

  irq_pend_bank #(.NIRQ(NI)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_line(line), .irq_edge(edgec), .irq_act(act),
    .cpu_running(cpu_run),
    .g_req(g_req), .g_we(g_we), .g_addr(g_addr), .g_wdata(g_wdata),
    .g_ack(g_ack), .g_rdata(g_rdata),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_ack(s_ack), .s_err(s_err), .s_rdata(s_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  function automatic bit cnt_ok(input logic [31:0] v);
    return v >= 64 && v <= NI && v[4:0] == 5'd0;
  endfunction

  function automatic logic [31:0] m_rd(input bit save, input logic [AW-1:0] a);
    logic [31:0] r = '0;
    int base = 32 * int'(a[1:0]);
    if (save && cpu_run) return '0;
    case (a[3:2])
      2'd0: if (a[1:0] == 2'd0) r = {30'd0, m_stat}; else if (a[1:0] == 2'd1) r = 32'(m_cnt);
      2'd1: for (int b = 0; b < 32; b++)
              r[b] = save ? m_latch[base+b] : (m_latch[base+b] | (!edgec[base+b] & m_lvl[base+b]));
      2'd2: if (!save) for (int b = 0; b < 32; b++)
              r[b] = m_latch[base+b] | (!edgec[base+b] & m_lvl[base+b]);
      default: if (save) for (int b = 0; b < 32; b++)
              r[b] = m_lvl[base+b] & (base + b >= 16) & (base + b < m_cnt);
    endcase
    return r;
  endfunction

  // reference update from the requirements, using the inputs held at this edge
  task automatic mdl_clock();
    logic [NI-1:0] nl, nv;
    logic [1:0] ns;
    bit s_ok = s_req && !cpu_run;
    for (int i = 0; i < NI; i++) begin
      bit gw = g_req && g_we && (int'(g_addr[1:0]) == i / 32) && g_wdata[i % 32];
      bit setv = (edgec[i] && line[i] && !m_prev[i]) || (gw && g_addr[3:2] == 2'd1);
      bit clrv = act[i] || (gw && g_addr[3:2] == 2'd2);
      bit hit = s_ok && s_we && (int'(s_addr[1:0]) == i / 32);
      bit basev = (hit && s_addr[3:2] == 2'd1) ? s_wdata[i % 32] : m_latch[i];
      nl[i] = setv || (basev && !clrv);
      if (line[i] != m_prev[i]) nv[i] = line[i];
      else if (hit && s_addr[3:2] == 2'd3 && i >= 16 && i < m_cnt) nv[i] = s_wdata[i % 32];
      else nv[i] = m_lvl[i];
    end
    ns = m_stat;
    if (g_req && g_we && g_addr == 4'd0) ns = ns & ~g_wdata[1:0];
    if (s_ok && s_we && s_addr == 4'd0) ns = s_wdata[1:0];
    if (s_req && cpu_run) ns[0] = 1'b1;
    if (s_ok && s_we && s_addr == 4'd1) begin
      if (cnt_ok(s_wdata)) m_cnt = int'(s_wdata);
      else ns[1] = 1'b1;
    end
    m_latch = nl; m_lvl = nv; m_prev = line; m_stat = ns;
  endtask

  task automatic cyc();
    @(posedge clk);
    mdl_clock();
    @(negedge clk);
  endtask

  task automatic gacc(input bit we, input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    logic [31:0] e;
    g_req = 1'b1; g_we = we; g_addr = a; g_wdata = d;
    e = we ? 32'd0 : m_rd(1'b0, a);
    cyc();
    g_req = 1'b0; g_we = 1'b0;
    chk(g_ack === 1'b1 && g_rdata === e, {tag, " guest"}, g_rdata, e);
  endtask

  task automatic sacc(input bit we, input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    logic [31:0] e;
    bit ee;
    s_req = 1'b1; s_we = we; s_addr = a; s_wdata = d;
    e = we ? 32'd0 : m_rd(1'b1, a);
    ee = cpu_run || (we && a == 4'd1 && !cnt_ok(d));
    cyc();
    s_req = 1'b0; s_we = 1'b0;
    chk(s_ack === 1'b1 && s_rdata === e, {tag, " save data"}, s_rdata, e);
    chk(s_err === ee, {tag, " save err"}, 32'(s_err), 32'(ee));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd1234);
    edgec[40] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk(g_ack === 1'b0 && s_ack === 1'b0, "R11 reset ack", 32'(g_ack), 0);
    gacc(0, 4'd0, 0, "R6 reset status");
    gacc(0, 4'd1, 0, "R8 reset count");
    gacc(0, 4'd5, 0, "R3 reset view");
    // edge latch and activation
    line[40] = 1'b1; cyc();
    gacc(0, 4'd5, 0, "R1 edge latched");
    line[40] = 1'b0; cyc();
    gacc(0, 4'd5, 0, "R1 held after line low");
    act[40] = 1'b1; cyc(); act[40] = 1'b0;
    gacc(0, 4'd5, 0, "R2 activation clears");
    // level view versus raw latch
    line[41] = 1'b1; cyc();
    gacc(0, 4'd5, 0, "R3 level view");
    sacc(0, 4'd5, 0, "R4 raw latch excludes line");
    gacc(1, 4'd9, 32'h0000_0200, "R3 clear while high");
    gacc(0, 4'd9, 0, "R3 still pending");
    line[41] = 1'b0; cyc();
    gacc(0, 4'd5, 0, "R3 line dropped");
    // set wins over activation
    act[42] = 1'b1;
    gacc(1, 4'd5, 32'h0000_0400, "R2 set with act");
    act[42] = 1'b0;
    gacc(0, 4'd5, 0, "R2 set wins");
    // raw load and clear-pending RAZ/WI
    sacc(1, 4'd6, 32'hA5A5_0F0F, "R4 load");
    sacc(0, 4'd6, 0, "R4 readback");
    sacc(1, 4'd10, 32'hFFFF_FFFF, "R5 write ignored");
    sacc(0, 4'd10, 0, "R5 raz");
    sacc(0, 4'd6, 0, "R5 latch unchanged");
    // busy refusal and status
    cpu_run = 1'b1;
    sacc(1, 4'd6, 32'd0, "R9 busy write");
    sacc(0, 4'd6, 0, "R9 busy read");
    cpu_run = 1'b0;
    sacc(0, 4'd6, 0, "R9 no effect");
    gacc(0, 4'd0, 0, "R6 busy bit");
    gacc(1, 4'd0, 32'h1, "R6 w1c");
    gacc(0, 4'd0, 0, "R6 cleared");
    // count range
    sacc(1, 4'd1, 32'd100, "R8 bad count");
    sacc(0, 4'd1, 0, "R8 count kept");
    sacc(1, 4'd1, 32'd32, "R8 below range");
    sacc(1, 4'd1, 32'd160, "R8 above range");
    gacc(0, 4'd0, 0, "R6 bad count bit");
    sacc(1, 4'd0, 32'hFFFF_FFFF, "R6 save load");
    gacc(0, 4'd0, 0, "R6 reserved zero");
    sacc(1, 4'd0, 32'h0, "R6 save load zero");
    sacc(0, 4'd0, 0, "R6 loaded");
    sacc(1, 4'd1, 32'd96, "R8 good count");
    sacc(0, 4'd1, 0, "R8 count taken");
    // line level access
    sacc(1, 4'd12, 32'hFFFF_FFFF, "R7 sgi mask");
    sacc(0, 4'd12, 0, "R7 sgi raz");
    sacc(1, 4'd15, 32'hFFFF_FFFF, "R7 beyond count");
    sacc(0, 4'd15, 0, "R7 beyond raz");
    sacc(1, 4'd13, 32'h0000_0100, "R7 restore edge id");
    sacc(0, 4'd5, 0, "R7 restore no edge");
    sacc(0, 4'd13, 0, "R7 level readback");
    gacc(0, 4'd5, 0, "R7 edge view ignores level");
    // read-only and guest line region
    gacc(1, 4'd1, 32'd64, "R10 count ro");
    gacc(0, 4'd1, 0, "R10 count kept");
    gacc(1, 4'd13, 32'd0, "R10 guest line wi");
    gacc(0, 4'd13, 0, "R10 guest line raz");
    sacc(0, 4'd13, 0, "R10 level unchanged");
    // constrained random mix
    for (int w = 0; w < 4; w++) edgec[32*w +: 32] = $urandom;
    for (int it = 0; it < 600; it++) begin
      for (int w = 0; w < 4; w++) begin
        line[32*w +: 32] = line[32*w +: 32] ^ ($urandom & $urandom & $urandom);
        act[32*w +: 32]  = $urandom & $urandom & $urandom & $urandom;
      end
      case ($urandom_range(0, 5))
        0: gacc(1, {2'd1, 2'($urandom)}, $urandom & $urandom, "R1 rnd set");
        1: gacc(1, {2'd2, 2'($urandom)}, $urandom, "R2 rnd clear");
        2: gacc(0, {2'($urandom_range(1, 2)), 2'($urandom)}, 0, "R3 rnd view");
        3: sacc(0, {2'($urandom_range(1, 3)), 2'($urandom)}, 0, "R4 rnd save read");
        4: sacc(1, {2'($urandom_range(1, 3)), 2'($urandom)}, $urandom, "R7 rnd save write");
        default: cyc();
      endcase
    end
    act = '0;
    for (int w = 0; w < 4; w++) begin
      gacc(0, {2'd1, 2'(w)}, 0, "R3 final view");
      sacc(0, {2'd1, 2'(w)}, 0, "R4 final latch");
      sacc(0, {2'd3, 2'(w)}, 0, "R7 final level");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule